// File: doc/BRIEF.md
# Four-Bank Shared Memory Arbiter

This block is an on-chip word memory split into four banks that can be reached independently. The banks are chosen by the two most significant address bits. The two lower banks are 24 bits wide and the two upper banks are 16 bits wide. Three requesters share the memory:

- a 16-bit data bus (DM);
- a 24-bit program bus (PM);
- a 24-bit DMA port.

In every cycle each request goes to the bank that its address selects. Requests that land in different banks are served together, so a DM transfer and a PM transfer can both finish in the same cycle.

When requests meet on one bank, a fixed order decides. DM always wins. PM is served next, and `pm_stall` tells it that it lost. DMA only gets a bank in a cycle when neither core bus asks for that bank. The DMA side uses a valid/ready handshake: the master keeps its request up until `dma_ready` shows the transfer was taken, so no DMA transfer is lost.

Writes take effect at the clock edge where they are granted. Reads return data with a valid strobe one cycle after the grant. Values move between port width and bank width with the 16-bit quantity in the upper bits of the 24-bit word:

- A 24-bit port reads a 16-bit bank with a zero low byte.
- The 16-bit port sees bits 23:8 of a wide bank.

Top module: `quad_bank_mem`

## Requirements
- R1: Address bits [ADDR_W-1:ADDR_W-2] select the bank. Banks 0 and 1 hold 24-bit words and banks 2 and 3 hold 16-bit words. The remaining low address bits select the word inside the bank. Each bank serves at most one requester per cycle.
- R2: When DM and PM request different banks in the same cycle, both are granted: `pm_stall` stays low and both accesses take effect.
- R3: When DM and PM request the same bank, DM is granted and `pm_stall` is high in that cycle. The PM access is not performed, so a stalled PM write leaves the bank contents unchanged.
- R4: `dma_ready` is high exactly when `dma_valid` is high and neither DM nor PM requests the bank that the DMA address selects. The DMA access is performed in that cycle.
- R5: A DMA request whose bank is taken by a core bus gets `dma_ready` low and is not performed. If it is held, it completes in the first cycle its bank is free, with the data it was presented with.
- R6: A granted read raises the port's rvalid with the data one cycle after the grant. A granted write commits at the grant edge, so a read of that word in the next cycle returns the new value. Rvalid is low in cycles following no granted read.
- R7: On a 24-bit port (PM, DMA), a 16-bit bank reads as {word, 8'h00}. On a write to a 16-bit bank, bits 23:8 are stored and bits 7:0 are ignored.
- R8: On the 16-bit DM port, a 24-bit bank reads as bits 23:8 of the stored word. A DM write to a 24-bit bank stores {dm_wdata, 8'h00}.
- R9: After synchronous reset, with no request applied, `dm_rvalid`, `pm_rvalid`, `dma_rvalid`, `pm_stall` and `dma_ready` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dm_req | input | 1 | DM bus access request |
| dm_we | input | 1 | DM write (1) or read (0) |
| dm_addr | input | ADDR_W | DM word address |
| dm_wdata | input | NARROW_W | DM write data |
| dm_rvalid | output | 1 | DM read data valid |
| dm_rdata | output | NARROW_W | DM read data |
| pm_req | input | 1 | PM bus access request |
| pm_we | input | 1 | PM write (1) or read (0) |
| pm_addr | input | ADDR_W | PM word address |
| pm_wdata | input | WIDE_W | PM write data |
| pm_stall | output | 1 | PM lost its bank to DM this cycle |
| pm_rvalid | output | 1 | PM read data valid |
| pm_rdata | output | WIDE_W | PM read data |
| dma_valid | input | 1 | DMA request present |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_addr | input | ADDR_W | DMA word address |
| dma_wdata | input | WIDE_W | DMA write data |
| dma_ready | output | 1 | DMA request accepted this cycle |
| dma_rvalid | output | 1 | DMA read data valid |
| dma_rdata | output | WIDE_W | DMA read data |

## Verification
The assertions assume that request inputs are known whenever `rst_n` is high. They also assume that a DMA master keeps its request in place while `dma_ready` is low; the R5 property depends on that. The bench respects both assumptions:

- It drives every input to a defined value on the falling edge.
- It holds `dma_valid`, address and data unchanged throughout each DMA wait.

The conflict sweep covers every combination of DM, PM and DMA bank targets. For each combination the expected stall, ready and read data are derived from a per-word model that the bench keeps itself.

// File: rtl/qbm_pkg.sv
// Package: qbm_pkg
// Shared constants and types for the four-bank memory arbiter.
// Assumes exactly four banks addressed by the top two address bits.
package qbm_pkg;
    localparam int NUM_BANKS  = 4;
    localparam int BANK_SEL_W = 2;
    localparam int NUM_WIDE   = 2;   // banks below this index are wide

    // bit positions inside a per-bank grant vector
    localparam int GNT_DM  = 0;
    localparam int GNT_PM  = 1;
    localparam int GNT_DMA = 2;
    localparam int GNT_W   = 3;

    typedef logic [BANK_SEL_W-1:0] bank_sel_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_DM   = 2'd1,
        SRC_PM   = 2'd2,
        SRC_DMA  = 2'd3
    } src_t;
endpackage

// File: rtl/qbm_arbiter.sv
// Module: qbm_arbiter
// Per-bank fixed-priority owner selection: DM over PM over DMA.
// Purely combinational. Assumes request inputs are known when used.
module qbm_arbiter
    import qbm_pkg::*;
(
    input  logic      dm_req,
    input  logic      pm_req,
    input  logic      dma_valid,
    input  bank_sel_t dm_bank,
    input  bank_sel_t pm_bank,
    input  bank_sel_t dma_bank,
    output logic      dm_gnt,
    output logic      pm_gnt,
    output logic      dma_gnt,
    output logic      pm_stall,
    output logic [NUM_BANKS-1:0][GNT_W-1:0] bank_gnt
);

    logic [NUM_BANKS-1:0] dm_own;
    logic [NUM_BANKS-1:0] pm_own;
    logic [NUM_BANKS-1:0] dma_own;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        src_t owner;

        // Purpose: pick the single owner of this bank for the cycle.
        always_comb begin
            if (dm_req && (dm_bank == bank_sel_t'(b)))
                owner = SRC_DM;
            else if (pm_req && (pm_bank == bank_sel_t'(b)))
                owner = SRC_PM;
            else if (dma_valid && (dma_bank == bank_sel_t'(b)))
                owner = SRC_DMA;
            else
                owner = SRC_NONE;
        end

        assign dm_own[b]  = (owner == SRC_DM);
        assign pm_own[b]  = (owner == SRC_PM);
        assign dma_own[b] = (owner == SRC_DMA);
        assign bank_gnt[b][GNT_DM]  = dm_own[b];
        assign bank_gnt[b][GNT_PM]  = pm_own[b];
        assign bank_gnt[b][GNT_DMA] = dma_own[b];
    end

    // Purpose: translate bank ownership back into per-requester grants.
    always_comb begin
        dm_gnt   = dm_req    && dm_own[dm_bank];
        pm_gnt   = pm_req    && pm_own[pm_bank];
        dma_gnt  = dma_valid && dma_own[dma_bank];
        pm_stall = pm_req    && !pm_own[pm_bank];
    end

endmodule

// File: rtl/qbm_bank.sv
// Module: qbm_bank
// One single-port synchronous RAM bank of DATA_W bits by 2**AW words.
// Write commits at the enabled edge; read data registers on that edge.
// Assumes at most one access per cycle (guaranteed by the arbiter).
module qbm_bank #(
    parameter int DATA_W = 24,
    parameter int AW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // Purpose: store write data at the grant edge.
    always_ff @(posedge clk) begin
        if (en && we)
            mem[addr] <= wdata;
    end

    // Purpose: register read data one cycle after the grant.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (en && !we)
            rdata <= mem[addr];
    end
endmodule

// File: rtl/qbm_rd_route.sv
// Module: qbm_rd_route
// Remembers which bank served each requester's read and returns that
// bank's 24-bit aligned lane the following cycle with a valid strobe.
// The 16-bit port takes the upper NARROW_W bits of the lane.
module qbm_rd_route
    import qbm_pkg::*;
#(
    parameter int WIDE_W   = 24,
    parameter int NARROW_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dm_fire,
    input  bank_sel_t             dm_bank,
    input  logic                  pm_fire,
    input  bank_sel_t             pm_bank,
    input  logic                  dma_fire,
    input  bank_sel_t             dma_bank,
    input  logic [NUM_BANKS-1:0][WIDE_W-1:0] bank_lane,
    output logic                  dm_rvalid,
    output logic [NARROW_W-1:0]   dm_rdata,
    output logic                  pm_rvalid,
    output logic [WIDE_W-1:0]     pm_rdata,
    output logic                  dma_rvalid,
    output logic [WIDE_W-1:0]     dma_rdata
);
    bank_sel_t dm_sel_q, pm_sel_q, dma_sel_q;

    // Purpose: capture read grants and the bank each one used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dm_rvalid  <= 1'b0;
            pm_rvalid  <= 1'b0;
            dma_rvalid <= 1'b0;
            dm_sel_q   <= '0;
            pm_sel_q   <= '0;
            dma_sel_q  <= '0;
        end else begin
            dm_rvalid  <= dm_fire;
            pm_rvalid  <= pm_fire;
            dma_rvalid <= dma_fire;
            if (dm_fire)  dm_sel_q  <= dm_bank;
            if (pm_fire)  pm_sel_q  <= pm_bank;
            if (dma_fire) dma_sel_q <= dma_bank;
        end
    end

    // Purpose: steer the served bank's lane to each read port.
    always_comb begin
        dm_rdata  = dm_rvalid  ? bank_lane[dm_sel_q][WIDE_W-1 -: NARROW_W] : '0;
        pm_rdata  = pm_rvalid  ? bank_lane[pm_sel_q]  : '0;
        dma_rdata = dma_rvalid ? bank_lane[dma_sel_q] : '0;
    end
endmodule

// File: rtl/quad_bank_mem.sv
// Module: quad_bank_mem
// Four-bank shared memory: two WIDE_W banks (0,1) and two NARROW_W banks
// (2,3), selected by the top two address bits. DM (NARROW_W) beats PM
// (WIDE_W) on a shared bank; DMA (WIDE_W) takes only banks left idle.
// Narrow values sit in the upper bits of the WIDE_W lane.
// Assumes WIDE_W > NARROW_W and the DMA master holds requests until ready.
module quad_bank_mem
    import qbm_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int WIDE_W   = 24,
    parameter int NARROW_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dm_req,
    input  logic                dm_we,
    input  logic [ADDR_W-1:0]   dm_addr,
    input  logic [NARROW_W-1:0] dm_wdata,
    output logic                dm_rvalid,
    output logic [NARROW_W-1:0] dm_rdata,
    input  logic                pm_req,
    input  logic                pm_we,
    input  logic [ADDR_W-1:0]   pm_addr,
    input  logic [WIDE_W-1:0]   pm_wdata,
    output logic                pm_stall,
    output logic                pm_rvalid,
    output logic [WIDE_W-1:0]   pm_rdata,
    input  logic                dma_valid,
    input  logic                dma_we,
    input  logic [ADDR_W-1:0]   dma_addr,
    input  logic [WIDE_W-1:0]   dma_wdata,
    output logic                dma_ready,
    output logic                dma_rvalid,
    output logic [WIDE_W-1:0]   dma_rdata
);
    localparam int OFF_W = ADDR_W - BANK_SEL_W;
    localparam int PAD_W = WIDE_W - NARROW_W;

    bank_sel_t  dm_bank, pm_bank, dma_bank;
    logic [OFF_W-1:0] dm_off, pm_off, dma_off;
    logic dm_gnt, pm_gnt, dma_gnt;
    logic [NUM_BANKS-1:0][GNT_W-1:0]  bank_gnt;
    logic [NUM_BANKS-1:0][WIDE_W-1:0] bank_lane;

    // Purpose: split each address into bank select and in-bank offset.
    always_comb begin
        dm_bank  = dm_addr[ADDR_W-1 -: BANK_SEL_W];
        pm_bank  = pm_addr[ADDR_W-1 -: BANK_SEL_W];
        dma_bank = dma_addr[ADDR_W-1 -: BANK_SEL_W];
        dm_off   = dm_addr[OFF_W-1:0];
        pm_off   = pm_addr[OFF_W-1:0];
        dma_off  = dma_addr[OFF_W-1:0];
    end

    qbm_arbiter u_arb (
        .dm_req    (dm_req),
        .pm_req    (pm_req),
        .dma_valid (dma_valid),
        .dm_bank   (dm_bank),
        .pm_bank   (pm_bank),
        .dma_bank  (dma_bank),
        .dm_gnt    (dm_gnt),
        .pm_gnt    (pm_gnt),
        .dma_gnt   (dma_gnt),
        .pm_stall  (pm_stall),
        .bank_gnt  (bank_gnt)
    );

    assign dma_ready = dma_gnt;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic             en, we;
        logic [OFF_W-1:0] addr;

        if (b < NUM_WIDE) begin : g_wide
            logic [WIDE_W-1:0] wdata, rdata;

            // Purpose: select the owner's command for this wide bank.
            always_comb begin
                en = 1'b1; we = 1'b0; addr = '0; wdata = '0;
                if (bank_gnt[b][GNT_DM]) begin
                    we = dm_we; addr = dm_off; wdata = {dm_wdata, {PAD_W{1'b0}}};
                end else if (bank_gnt[b][GNT_PM]) begin
                    we = pm_we; addr = pm_off; wdata = pm_wdata;
                end else if (bank_gnt[b][GNT_DMA]) begin
                    we = dma_we; addr = dma_off; wdata = dma_wdata;
                end else begin
                    en = 1'b0;
                end
            end

            qbm_bank #(.DATA_W(WIDE_W), .AW(OFF_W)) u_ram (
                .clk(clk), .rst_n(rst_n), .en(en), .we(we),
                .addr(addr), .wdata(wdata), .rdata(rdata)
            );

            assign bank_lane[b] = rdata;
        end else begin : g_narrow
            logic [NARROW_W-1:0] wdata, rdata;

            // Purpose: select the owner's command for this narrow bank.
            always_comb begin
                en = 1'b1; we = 1'b0; addr = '0; wdata = '0;
                if (bank_gnt[b][GNT_DM]) begin
                    we = dm_we; addr = dm_off; wdata = dm_wdata;
                end else if (bank_gnt[b][GNT_PM]) begin
                    we = pm_we; addr = pm_off; wdata = pm_wdata[WIDE_W-1 -: NARROW_W];
                end else if (bank_gnt[b][GNT_DMA]) begin
                    we = dma_we; addr = dma_off; wdata = dma_wdata[WIDE_W-1 -: NARROW_W];
                end else begin
                    en = 1'b0;
                end
            end

            qbm_bank #(.DATA_W(NARROW_W), .AW(OFF_W)) u_ram (
                .clk(clk), .rst_n(rst_n), .en(en), .we(we),
                .addr(addr), .wdata(wdata), .rdata(rdata)
            );

            assign bank_lane[b] = {rdata, {PAD_W{1'b0}}};
        end
    end

    qbm_rd_route #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .dm_fire    (dm_gnt && !dm_we),
        .dm_bank    (dm_bank),
        .pm_fire    (pm_gnt && !pm_we),
        .pm_bank    (pm_bank),
        .dma_fire   (dma_gnt && !dma_we),
        .dma_bank   (dma_bank),
        .bank_lane  (bank_lane),
        .dm_rvalid  (dm_rvalid),
        .dm_rdata   (dm_rdata),
        .pm_rvalid  (pm_rvalid),
        .pm_rdata   (pm_rdata),
        .dma_rvalid (dma_rvalid),
        .dma_rdata  (dma_rdata)
    );
endmodule

// File: rtl/qbm_checker.sv
// Module: qbm_checker
// Protocol and arbitration properties for quad_bank_mem, attached by bind.
// Assumes request inputs are known while rst_n is high.
module qbm_checker
    import qbm_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dm_req,
    input logic              dm_we,
    input logic [ADDR_W-1:0] dm_addr,
    input logic              dm_rvalid,
    input logic              pm_req,
    input logic              pm_we,
    input logic [ADDR_W-1:0] pm_addr,
    input logic              pm_stall,
    input logic              pm_rvalid,
    input logic              dma_valid,
    input logic              dma_we,
    input logic [ADDR_W-1:0] dma_addr,
    input logic              dma_ready,
    input logic              dma_rvalid,
    input logic [NUM_BANKS-1:0][GNT_W-1:0] bank_gnt
);
    bank_sel_t cb_dm, cb_pm, cb_dma;
    assign cb_dm  = dm_addr[ADDR_W-1 -: BANK_SEL_W];
    assign cb_pm  = pm_addr[ADDR_W-1 -: BANK_SEL_W];
    assign cb_dma = dma_addr[ADDR_W-1 -: BANK_SEL_W];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_own
        // R1: one owner per bank per cycle
        a_r1_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(bank_gnt[b]));
    end

    a_r2_apart_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_req && pm_req && cb_dm != cb_pm) |-> !pm_stall);

    a_r3_stall_needs_clash: assert property (@(posedge clk) disable iff (!rst_n)
        pm_stall |-> (pm_req && dm_req && cb_dm == cb_pm));

    a_r4_ready_on_free_bank: assert property (@(posedge clk) disable iff (!rst_n)
        dma_ready |-> (dma_valid && !(dm_req && cb_dm == cb_dma)
                                 && !(pm_req && cb_pm == cb_dma)));

    a_r5_idle_core_lets_dma: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_valid && !dm_req && !pm_req) |-> dma_ready);

    a_r6_dm_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_req && !dm_we) |=> dm_rvalid);

    a_r6_pm_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_req && !pm_we && !pm_stall) |=> pm_rvalid);

    a_r6_dma_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_ready && !dma_we) |=> !dma_rvalid);
endmodule

bind quad_bank_mem qbm_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dm_req     (dm_req),
    .dm_we      (dm_we),
    .dm_addr    (dm_addr),
    .dm_rvalid  (dm_rvalid),
    .pm_req     (pm_req),
    .pm_we      (pm_we),
    .pm_addr    (pm_addr),
    .pm_stall   (pm_stall),
    .pm_rvalid  (pm_rvalid),
    .dma_valid  (dma_valid),
    .dma_we     (dma_we),
    .dma_addr   (dma_addr),
    .dma_ready  (dma_ready),
    .dma_rvalid (dma_rvalid),
    .bank_gnt   (bank_gnt)
);

// File: tb/quad_bank_mem_tb.sv
// Bench for quad_bank_mem: full-memory fill/readback sweeps over all ports
// and an exhaustive DM/PM/DMA bank-target conflict sweep.
module quad_bank_mem_tb;
    localparam int AW  = 10;
    localparam int OFF = 8;
    localparam int WORDS = 1 << OFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic dm_req = 0, dm_we = 0;       logic [AW-1:0] dm_addr = '0;  logic [15:0] dm_wdata = '0;
    logic dm_rvalid;                   logic [15:0] dm_rdata;
    logic pm_req = 0, pm_we = 0;       logic [AW-1:0] pm_addr = '0;  logic [23:0] pm_wdata = '0;
    logic pm_stall, pm_rvalid;         logic [23:0] pm_rdata;
    logic dma_valid = 0, dma_we = 0;   logic [AW-1:0] dma_addr = '0; logic [23:0] dma_wdata = '0;
    logic dma_ready, dma_rvalid;       logic [23:0] dma_rdata;

    quad_bank_mem u_dut (
        .clk(clk), .rst_n(rst_n),
        .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
        .dm_rvalid(dm_rvalid), .dm_rdata(dm_rdata),
        .pm_req(pm_req), .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
        .pm_stall(pm_stall), .pm_rvalid(pm_rvalid), .pm_rdata(pm_rdata),
        .dma_valid(dma_valid), .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
        .dma_ready(dma_ready), .dma_rvalid(dma_rvalid), .dma_rdata(dma_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [23:0] model [4][WORDS];   // aligned 24-bit lane per word

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] ad(input int b, input int o);
        return {2'(b), 8'(o)};
    endfunction

    function automatic logic [23:0] pat(input int b, input int o, input int k);
        return 24'(b * 'h3A1 + o * 'h1F3 + k * 'h5B5C7 + 'h0A5C3);
    endfunction

    // lane stored by a 24-bit port write (R7)
    function automatic logic [23:0] lane24(input int b, input logic [23:0] d);
        return (b >= 2) ? {d[23:8], 8'h00} : d;
    endfunction

    task automatic tick(); @(negedge clk); endtask

    task automatic idle();
        dm_req = 0; dm_we = 0; pm_req = 0; pm_we = 0; dma_valid = 0; dma_we = 0;
    endtask

    task automatic dma_wr(input int b, input int o, input logic [23:0] d);
        dma_valid = 1; dma_we = 1; dma_addr = ad(b, o); dma_wdata = d;
        #1 chk("R4", "dma_ready idle bank", 32'(dma_ready), 1);
        tick(); idle();
        model[b][o] = lane24(b, d);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [23:0] v;
        repeat (3) tick();
        rst_n = 1;
        #1;
        chk("R9", "dm_rvalid", 32'(dm_rvalid), 0);
        chk("R9", "pm_rvalid", 32'(pm_rvalid), 0);
        chk("R9", "dma_rvalid", 32'(dma_rvalid), 0);
        chk("R9", "pm_stall", 32'(pm_stall), 0);
        chk("R9", "dma_ready", 32'(dma_ready), 0);
        tick();

        // R1 R7: fill every word of every bank through the DMA port
        for (int b = 0; b < 4; b++)
            for (int o = 0; o < WORDS; o++)
                dma_wr(b, o, pat(b, o, 0));

        // R1 R7 R8: read every word through DM and PM in different banks
        for (int b = 0; b < 4; b++) begin
            for (int o = 0; o < WORDS; o++) begin
                dm_req = 1; dm_we = 0; dm_addr = ad(b, o);
                pm_req = 1; pm_we = 0; pm_addr = ad(b ^ 1, o);
                #1 chk("R2", "pm_stall apart", 32'(pm_stall), 0);
                tick(); idle();
                chk("R6", "dm_rvalid", 32'(dm_rvalid), 1);
                chk("R8", "dm_rdata", 32'(dm_rdata), 32'(model[b][o][23:8]));
                chk("R7", "pm_rdata", 32'(pm_rdata), 32'(model[b ^ 1][o]));
            end
        end

        // R8: DM writes to wide banks, PM reads back with zero low byte
        for (int b = 0; b < 2; b++) begin
            dm_req = 1; dm_we = 1; dm_addr = ad(b, 17); dm_wdata = 16'hBE00 + 16'(b);
            tick(); idle();
            model[b][17] = {16'hBE00 + 16'(b), 8'h00};
            chk("R6", "dm_rvalid after write", 32'(dm_rvalid), 0);
            pm_req = 1; pm_addr = ad(b, 17);
            tick(); idle();
            chk("R8", "wide bank after DM write", 32'(pm_rdata), 32'(model[b][17]));
        end

        // R2 R3 R4: exhaustive DM/PM/DMA bank targets, reading word 9
        for (int db = 0; db < 4; db++)
            for (int pb = 0; pb < 4; pb++)
                for (int xb = 0; xb < 4; xb++) begin
                    logic rdy_e;
                    rdy_e = (xb != db) && (xb != pb);
                    dm_req = 1; dm_we = 0; dm_addr = ad(db, 9);
                    pm_req = 1; pm_we = 0; pm_addr = ad(pb, 9);
                    dma_valid = 1; dma_we = 0; dma_addr = ad(xb, 9);
                    #1;
                    chk("R3", "pm_stall sweep", 32'(pm_stall), 32'(db == pb));
                    chk("R4", "dma_ready sweep", 32'(dma_ready), 32'(rdy_e));
                    tick(); idle();
                    chk("R3", "pm_rvalid sweep", 32'(pm_rvalid), 32'(db != pb));
                    chk("R4", "dma_rvalid sweep", 32'(dma_rvalid), 32'(rdy_e));
                    chk("R2", "dm_rdata sweep", 32'(dm_rdata), 32'(model[db][9][23:8]));
                    if (db != pb) chk("R2", "pm_rdata sweep", 32'(pm_rdata), 32'(model[pb][9]));
                    if (rdy_e)    chk("R4", "dma_rdata sweep", 32'(dma_rdata), 32'(model[xb][9]));
                end

        // R3: stalled PM write leaves the word unchanged
        dm_req = 1; dm_addr = ad(1, 6);
        pm_req = 1; pm_we = 1; pm_addr = ad(1, 6); pm_wdata = 24'h123456;
        #1 chk("R3", "pm_stall same bank", 32'(pm_stall), 1);
        tick(); idle();
        pm_req = 1; pm_addr = ad(1, 6);
        tick(); idle();
        chk("R3", "stalled write dropped", 32'(pm_rdata), 32'(model[1][6]));

        // R5: DMA write held behind DM for three cycles, then completes
        v = 24'hC3A5F0;
        dma_valid = 1; dma_we = 1; dma_addr = ad(2, 4); dma_wdata = v;
        dm_req = 1; dm_addr = ad(2, 3);
        for (int i = 0; i < 3; i++) begin
            #1 chk("R5", "dma held off", 32'(dma_ready), 0);
            tick();
        end
        chk("R5", "word untouched while waiting", 32'(dm_rdata), 32'(model[2][3][23:8]));
        dm_req = 0;
        #1 chk("R5", "dma taken when free", 32'(dma_ready), 1);
        tick(); idle();
        model[2][4] = lane24(2, v);
        dma_valid = 1; dma_addr = ad(2, 4);
        tick(); idle();
        chk("R5", "held dma data stored", 32'(dma_rdata), 32'(model[2][4]));

        // R6: write then immediate read of the same word on PM
        pm_req = 1; pm_we = 1; pm_addr = ad(0, 40); pm_wdata = 24'h5A6B7C;
        tick();
        model[0][40] = 24'h5A6B7C;
        pm_we = 0;
        tick(); idle();
        chk("R6", "pm_rvalid next cycle", 32'(pm_rvalid), 1);
        chk("R6", "write visible next cycle", 32'(pm_rdata), 32'(model[0][40]));
        tick();
        chk("R6", "pm_rvalid drops", 32'(pm_rvalid), 0);

        // R7: PM write to narrow bank drops low byte
        pm_req = 1; pm_we = 1; pm_addr = ad(3, 50); pm_wdata = 24'h89ABCD;
        tick();
        model[3][50] = lane24(3, 24'h89ABCD);
        pm_we = 0;
        tick(); idle();
        chk("R7", "narrow low byte zero", 32'(pm_rdata), 32'h89AB00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule